// File: doc/BRIEF.md
# DMA Channel Request Handshake Unit

This block is the peripheral-facing handshake logic of one DMA channel. It senses an external active-low request pin, turns it into a transfer request for the channel's transfer engine according to the configured request mode, and shapes each bus cycle that the engine launches: it drives an active-low acknowledge strobe (optionally in a delayed form for slower memories), holds the second phase of the cycle open until the device signals readiness when the channel works in single-address fashion, and manages an active-low, bidirectional "done" line that marks the final operand.

The transfer engine sees a request flag, launches cycles with a start pulse (with a flag saying whether this is the last transfer) and gets back a cycle-active level, a one-clock completion pulse and a one-clock end-of-sequence pulse. The done line is presented as separate input, output and output-enable signals so that the pad ring can build the open-drain pin. Address generation, byte counting, bus arbitration and pin multiplexing live elsewhere.

Top module: `dma_req_handshake`

## Requirements
- R1: The request pin passes through a two-flop synchronizer. In burst mode (`cfg_mode` = 2'b01) `xfer_req_o` is level sensitive: it rises two clocks after `req_n_i` falls and drops two clocks after `req_n_i` rises.
- R2: In cycle-steal mode (`cfg_mode` = 2'b10) each high-to-low transition of `req_n_i` sets a pending request seen on `xfer_req_o` three clocks after the pin falls; holding the pin low creates no further request, and the pending request stays until accepted by `eng_start` while `xfer_req_o` is high, clearing at that clock.
- R3: In internal request mode (`cfg_mode` = 2'b00, and 2'b11 treated alike) `xfer_req_o` stays low whatever `req_n_i` does.
- R4: `eng_start` while idle opens a cycle: from the next clock `cyc_active_o` is high and `ack_n_o` low; a dual-address cycle (`cfg_single` = 0) lasts two clocks, after which `cyc_done_o` is high for exactly one clock with `ack_n_o` released.
- R5: With `cfg_ack_delay` = 1 the acknowledge goes low one clock later than in the normal form and is released at the same clock as the normal form.
- R6: With `cfg_single` = 1 the second phase repeats for every clock edge at which `rdy_n_i` is high and the cycle completes at the first edge in that phase where `rdy_n_i` is low.
- R7: In the external modes (2'b01, 2'b10), for a cycle started with `eng_last` = 1, `done_oe_o` is high and `done_n_o` low during every clock of the cycle; in internal mode `done_oe_o` never rises.
- R8: `done_n_i` is honoured in every mode: if it is low at any clock edge while a cycle is active, `seq_end_o` pulses together with `cyc_done_o`; `seq_end_o` also pulses at completion of a cycle started with `eng_last` = 1, and otherwise stays low.
- R9: A synchronous active-high `rst` clears any pending request, returns the cycle to idle, releases the acknowledge and the done output and its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Request mode: 00 internal, 01 burst, 10 cycle steal |
| cfg_ack_delay | input | 1 | Selects the delayed acknowledge form |
| cfg_single | input | 1 | Single-address transfers, ready-paced |
| req_n_i | input | 1 | External request pin, active low, asynchronous |
| rdy_n_i | input | 1 | Device ready, active low |
| done_n_i | input | 1 | Done pin as seen from the pad, active low |
| eng_start | input | 1 | Engine launches a cycle (and accepts a pending request) |
| eng_last | input | 1 | The launched cycle carries the final operand |
| xfer_req_o | output | 1 | Transfer request to the engine |
| cyc_active_o | output | 1 | A bus cycle is in progress |
| cyc_done_o | output | 1 | One-clock pulse at cycle completion |
| seq_end_o | output | 1 | One-clock pulse: sequence finished |
| ack_n_o | output | 1 | Acknowledge strobe, active low |
| done_n_o | output | 1 | Done pin output value, active low |
| done_oe_o | output | 1 | Done pin output enable |

## Verification
A table of cycles is walked in which request mode, acknowledge form, single or dual addressing, the last flag, an external done pulse and the number of ready wait states are varied together; per cycle the bench counts the clocks of acknowledge and of done drive and checks the completion timing, which separates the normal from the delayed strobe, a ready-stretched from a fixed-length cycle and a driven from an undriven done. Directed runs then hold and toggle the request pin in each mode, which tells level from edge sensing (a held-low pin must not re-request in cycle-steal mode) and shows that internal mode ignores the pin, and a reset in the middle of a driven last cycle shows everything released.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;
  typedef enum logic [1:0] {
    MODE_INTERNAL = 2'b00,
    MODE_BURST    = 2'b01,
    MODE_STEAL    = 2'b10,
    MODE_RSVD     = 2'b11
  } req_mode_t;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'b00,
    CYC_ADDR  = 2'b01,
    CYC_DATA  = 2'b10
  } cyc_state_t;

  function automatic logic is_ext_mode(input logic [1:0] m);
    return (m == MODE_BURST) || (m == MODE_STEAL);
  endfunction
endpackage

// File: rtl/dmahs_req_sense.sv
module dmahs_req_sense
  import dmahs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       req_n_i,
  input  logic       accept,
  output logic       xfer_req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q;
  logic                   req_n_s;
  logic                   fall;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= req_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign req_n_s = sync_q[SYNC_STAGES-1];
  assign fall    = prev_q & ~req_n_s;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= req_n_s;
  end

  always_ff @(posedge clk) begin
    if (rst || mode != MODE_STEAL) pend_q <= 1'b0;
    else if (fall)                 pend_q <= 1'b1;
    else if (accept)               pend_q <= 1'b0;
  end

  always_comb begin
    case (mode)
      MODE_BURST: xfer_req = ~req_n_s;
      MODE_STEAL: xfer_req = pend_q;
      default:    xfer_req = 1'b0;
    endcase
  end

  // R2: a pending request survives until accepted
  p_pend_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !accept && mode == MODE_STEAL) |=> pend_q)
    else $error("pending request lost");

  // R2: a detected falling edge always produces a pending request
  p_fall_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (fall && mode == MODE_STEAL && $stable(mode)) |=> pend_q)
    else $error("falling edge not latched");
endmodule

// File: rtl/dmahs_cycle_fsm.sv
module dmahs_cycle_fsm
  import dmahs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_ack_delay,
  input  logic cfg_single,
  input  logic eng_start,
  input  logic rdy_n_i,
  output logic start,
  output logic active_nxt,
  output logic complete,
  output logic cyc_active,
  output logic cyc_done,
  output logic ack_n
);
  cyc_state_t state_q, state_d;
  logic       ack_q;
  logic       done_q;

  assign start    = (state_q == CYC_IDLE) && eng_start;
  assign complete = (state_q == CYC_DATA) && (!cfg_single || !rdy_n_i);

  always_comb begin
    state_d = state_q;
    case (state_q)
      CYC_IDLE: if (eng_start) state_d = CYC_ADDR;
      CYC_ADDR: state_d = CYC_DATA;
      CYC_DATA: if (complete) state_d = CYC_IDLE;
      default:  state_d = CYC_IDLE;
    endcase
  end

  assign active_nxt = (state_d != CYC_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CYC_IDLE;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= cfg_ack_delay ? (state_d == CYC_DATA) : active_nxt;
      done_q  <= complete;
    end
  end

  assign cyc_active = (state_q != CYC_IDLE);
  assign cyc_done   = done_q;
  assign ack_n      = ~ack_q;

  // R5: the delayed strobe only shows in the second phase
  p_dly_phase_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_ack_delay && ack_q) |-> (state_q == CYC_DATA))
    else $error("delayed acknowledge outside second phase");

  // R6: ready high holds the cycle in its wait phase
  p_rdy_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == CYC_DATA && cfg_single && rdy_n_i) |=> (state_q == CYC_DATA))
    else $error("cycle left wait state without ready");

  // R4: completion pulse only when back in idle
  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (state_q == CYC_IDLE && ack_n))
    else $error("completion pulse during active cycle");
endmodule

// File: rtl/dmahs_done_ctl.sv
module dmahs_done_ctl
  import dmahs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       start,
  input  logic       eng_last,
  input  logic       active_nxt,
  input  logic       cyc_active,
  input  logic       complete,
  input  logic       done_n_i,
  output logic       seq_end,
  output logic       done_n_o,
  output logic       done_oe
);
  logic last_q;
  logic seen_q;
  logic oe_q;
  logic out_n_q;
  logic seq_q;
  logic last_now;
  logic drive;

  assign last_now = start ? eng_last : last_q;
  assign drive    = is_ext_mode(mode) && last_now && active_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= 1'b0;
      seen_q  <= 1'b0;
      oe_q    <= 1'b0;
      out_n_q <= 1'b1;
      seq_q   <= 1'b0;
    end else begin
      last_q  <= last_now;
      if (start)                        seen_q <= 1'b0;
      else if (cyc_active && !done_n_i) seen_q <= 1'b1;
      oe_q    <= drive;
      out_n_q <= ~drive;
      seq_q   <= complete && (last_q || seen_q || !done_n_i);
    end
  end

  assign seq_end  = seq_q;
  assign done_n_o = out_n_q;
  assign done_oe  = oe_q;

  // R7: the pin is enabled only in external request modes
  p_oe_ext_r7: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> is_ext_mode(mode))
    else $error("done driven in internal mode");

  // R7: whenever enabled, the driven value is the asserted level
  p_oe_low_r7: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> !out_n_q)
    else $error("done enabled but not asserted");
endmodule

// File: rtl/dma_req_handshake.sv
module dma_req_handshake
  import dmahs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_ack_delay,
  input  logic       cfg_single,
  input  logic       req_n_i,
  input  logic       rdy_n_i,
  input  logic       done_n_i,
  input  logic       eng_start,
  input  logic       eng_last,
  output logic       xfer_req_o,
  output logic       cyc_active_o,
  output logic       cyc_done_o,
  output logic       seq_end_o,
  output logic       ack_n_o,
  output logic       done_n_o,
  output logic       done_oe_o
);
  logic start;
  logic active_nxt;
  logic complete;
  logic accept;

  assign accept = eng_start && xfer_req_o;

  dmahs_req_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk      (clk),
    .rst      (rst),
    .mode     (cfg_mode),
    .req_n_i  (req_n_i),
    .accept   (accept),
    .xfer_req (xfer_req_o)
  );

  dmahs_cycle_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .cfg_ack_delay (cfg_ack_delay),
    .cfg_single    (cfg_single),
    .eng_start     (eng_start),
    .rdy_n_i       (rdy_n_i),
    .start         (start),
    .active_nxt    (active_nxt),
    .complete      (complete),
    .cyc_active    (cyc_active_o),
    .cyc_done      (cyc_done_o),
    .ack_n         (ack_n_o)
  );

  dmahs_done_ctl u_done (
    .clk        (clk),
    .rst        (rst),
    .mode       (cfg_mode),
    .start      (start),
    .eng_last   (eng_last),
    .active_nxt (active_nxt),
    .cyc_active (cyc_active_o),
    .complete   (complete),
    .done_n_i   (done_n_i),
    .seq_end    (seq_end_o),
    .done_n_o   (done_n_o),
    .done_oe    (done_oe_o)
  );

  // R9: reset releases every strobe and request
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (ack_n_o && !done_oe_o && done_n_o && !xfer_req_o && !cyc_active_o))
    else $error("reset left outputs active");

  // R8: end of sequence only accompanies a completion
  p_seq_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    seq_end_o |-> cyc_done_o)
    else $error("sequence end without cycle completion");
endmodule

// File: tb/dma_req_handshake_tb.sv
`timescale 1ns/1ps
module dma_req_handshake_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_ack_delay = 1'b0;
  logic       cfg_single = 1'b0;
  logic       req_n_i = 1'b1;
  logic       rdy_n_i = 1'b1;
  logic       done_n_i = 1'b1;
  logic       eng_start = 1'b0;
  logic       eng_last = 1'b0;
  logic       xfer_req_o, cyc_active_o, cyc_done_o, seq_end_o;
  logic       ack_n_o, done_n_o, done_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  always #2.5 clk = ~clk;

  dma_req_handshake u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_ack_delay(cfg_ack_delay),
    .cfg_single(cfg_single), .req_n_i(req_n_i), .rdy_n_i(rdy_n_i),
    .done_n_i(done_n_i), .eng_start(eng_start), .eng_last(eng_last),
    .xfer_req_o(xfer_req_o), .cyc_active_o(cyc_active_o), .cyc_done_o(cyc_done_o),
    .seq_end_o(seq_end_o), .ack_n_o(ack_n_o), .done_n_o(done_n_o), .done_oe_o(done_oe_o)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       dly;
    logic       single;
    logic       last;
    logic       xdone;
    logic [2:0] wt;
    logic [3:0] len;
    logic [3:0] ack;
    logic [3:0] oe;
    logic       seq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd3, 4'd2, 4'd0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 4'd3, 4'd1, 4'd2, 1'b1},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 4'd5, 4'd4, 4'd0, 1'b0},
    '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 4'd6, 4'd4, 4'd5, 1'b1},
    '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 4'd3, 4'd2, 4'd0, 1'b1},
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 4'd4, 4'd3, 4'd0, 1'b1},
    '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 4'd3, 4'd2, 4'd2, 1'b1},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 4'd3, 4'd1, 4'd0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    edges(3);
    // R9: reset state
    check("R9 ack_n after reset", ack_n_o, 1);
    check("R9 done_oe after reset", done_oe_o, 0);
    check("R9 done_n after reset", done_n_o, 1);
    check("R9 xfer_req after reset", xfer_req_o, 0);
    check("R9 cyc_active after reset", cyc_active_o, 0);
    rst = 1'b0;
    edges(2);

    // table of cycles: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      int len_seen;
      int ack_seen;
      int oe_seen;
      int act1;
      int seq_seen;
      cfg_mode = VEC[v].mode;
      cfg_ack_delay = VEC[v].dly;
      cfg_single = VEC[v].single;
      edges(2);
      eng_start = 1'b1;
      eng_last = VEC[v].last;
      rdy_n_i = 1'b1;
      len_seen = 0; ack_seen = 0; oe_seen = 0; act1 = 0; seq_seen = 0;
      for (int k = 1; k < 20; k++) begin
        @(posedge clk);
        @(negedge clk);
        eng_start = 1'b0;
        if (k == 1) act1 = cyc_active_o;
        if (!ack_n_o) ack_seen++;
        if (done_oe_o && !done_n_o) oe_seen++;
        rdy_n_i = !(k >= 2 + int'(VEC[v].wt));
        done_n_i = !(VEC[v].xdone && k == 1);
        if (cyc_done_o) begin
          len_seen = k;
          seq_seen = seq_end_o;
          break;
        end
      end
      done_n_i = 1'b1;
      rdy_n_i = 1'b1;
      check($sformatf("R4 vec%0d cycle active", v), act1, 1);
      check($sformatf("R6 vec%0d cycle length", v), len_seen, VEC[v].len);
      check($sformatf("R5 vec%0d ack clocks", v), ack_seen, VEC[v].ack);
      check($sformatf("R7 vec%0d done drive clocks", v), oe_seen, VEC[v].oe);
      check($sformatf("R8 vec%0d seq_end", v), seq_seen, VEC[v].seq);
      edges(1);
      check($sformatf("R4 vec%0d done pulse one clock", v), cyc_done_o, 0);
    end

    // R1: burst mode level sensing
    cfg_mode = 2'b01; cfg_ack_delay = 1'b0; cfg_single = 1'b0;
    edges(3);
    req_n_i = 1'b0;
    edges(1);
    check("R1 burst req after 1 clk", xfer_req_o, 0);
    edges(1);
    check("R1 burst req after 2 clk", xfer_req_o, 1);
    edges(4);
    check("R1 burst req held level", xfer_req_o, 1);
    req_n_i = 1'b1;
    edges(1);
    check("R1 burst release after 1 clk", xfer_req_o, 1);
    edges(1);
    check("R1 burst release after 2 clk", xfer_req_o, 0);

    // R3: internal mode ignores the pin
    cfg_mode = 2'b00;
    edges(2);
    req_n_i = 1'b0;
    edges(3);
    check("R3 internal req low", xfer_req_o, 0);
    req_n_i = 1'b1;
    edges(2);
    req_n_i = 1'b0;
    edges(4);
    check("R3 internal after toggle", xfer_req_o, 0);
    req_n_i = 1'b1;
    edges(4);

    // R2: cycle-steal edge sensing
    cfg_mode = 2'b10;
    edges(3);
    req_n_i = 1'b0;
    edges(2);
    check("R2 steal req after 2 clk", xfer_req_o, 0);
    edges(1);
    check("R2 steal req after 3 clk", xfer_req_o, 1);
    edges(5);
    check("R2 steal pending held", xfer_req_o, 1);
    eng_start = 1'b1; eng_last = 1'b0;
    edges(1);
    eng_start = 1'b0;
    check("R2 steal cleared by accept", xfer_req_o, 0);
    edges(8);
    check("R2 held-low pin no new request", xfer_req_o, 0);
    req_n_i = 1'b1;
    edges(4);
    req_n_i = 1'b0;
    edges(3);
    check("R2 second edge requests", xfer_req_o, 1);

    // R9: reset clears pending request
    rst = 1'b1;
    edges(1);
    check("R9 reset clears pending", xfer_req_o, 0);
    req_n_i = 1'b1;
    rst = 1'b0;
    edges(4);

    // R9: reset in the middle of a driven last cycle
    cfg_mode = 2'b01;
    edges(2);
    eng_start = 1'b1; eng_last = 1'b1;
    edges(1);
    eng_start = 1'b0; eng_last = 1'b0;
    check("R7 done enabled mid cycle", done_oe_o, 1);
    rst = 1'b1;
    edges(1);
    check("R9 mid-cycle reset ack", ack_n_o, 1);
    check("R9 mid-cycle reset oe", done_oe_o, 0);
    check("R9 mid-cycle reset active", cyc_active_o, 0);
    rst = 1'b0;
    edges(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule